// File: doc/BRIEF.md
# Byte-Wide Register Target on a Two-Wire Serial Bus

This block is a two-wire serial (I2C) target that lets an off-chip host read and write a small bank of 8-bit control registers. It oversamples the clock and data lines with the system clock. It finds start and stop conditions from SDA edges seen while SCL is high. It drives SDA only through an active-high pull-down enable.

A write transaction has three parts. The first is the 7-bit target address with a direction bit. The second is a pointer byte. Its low seven bits select a register and its top bit picks the stepping mode. Any bytes that follow are data for the selected register.

A read has no pointer byte of its own. It returns data from the pointer that the last write left behind, even if a stop came in between. When the top bit of the pointer is set, the pointer moves on by one after every data byte, in either direction. This allows block transfers. Four consecutive registers hold a 32-bit ratio word. That word is also driven onto a port, with the lowest address as its most significant byte.

Top module: `i2cRegTarget`

## Requirements
- R1: After reset the block does not pull SDA low. Register 01h reads as {00000, REV_CODE}, which is 05h by default. Registers 02h, 03h, 05h, 06h to 09h, 16h and 17h read 00h.
- R2: The target answers only to address 7'b100111s, where s is the `addrStrap` input. Direction bit 1 means read. For any other address it gives no acknowledge and leaves SDA released until the next start or stop.
- R3: The target acknowledges the address byte, the pointer byte and every written data byte. It does this by pulling SDA low during the ninth clock. The first byte after a write address always loads the pointer.
- R4: When pointer bit 7 is 0, every data byte of the transaction, whether read or written, uses the same register.
- R5: When pointer bit 7 is 1, the 7-bit register index steps by one after each data byte read or written. It wraps from 7Fh to 00h.
- R6: The pointer is held across a stop. A later read transaction starts at the register that the pointer selects.
- R7: Writes to 01h or to addresses that are not implemented are acknowledged and then discarded. Unimplemented addresses read 00h. Only bits 4:0 of register 02h can be written; bits 7:5 read 0.
- R8: Registers 06h, 07h, 08h and 09h appear on `ratioWord` as bits 31:24, 23:16, 15:8 and 7:0 in that order.
- R9: Read data goes out MSB first. If the controller answers a read byte with a NACK (SDA high), the read ends and the target keeps SDA released from then on.
- R10: A start or stop in the middle of a byte abandons that byte and leaves the pointer as it was. A start in that position begins a new address phase.
- R11: `sdaLowEn` changes only while SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Asynchronous active-low reset |
| addrStrap | input | 1 | Value of the least significant bit of the target address |
| sclIn | input | 1 | Bus clock line as seen at the pad |
| sdaIn | input | 1 | Bus data line as seen at the pad |
| sdaLowEn | output | 1 | When 1, the pad pulls SDA low |
| ratioWord | output | 32 | The 32-bit ratio held in registers 06h to 09h |

## Verification
Two functions can fall in the same cycle: the register write and the pointer step. Both happen at the eighth SCL rise of a data byte when stepping is enabled. The bench writes four bytes as a block into 06h to 09h and compares `ratioWord` with the expected word. A wrong pairing of write and step would shift or lose a byte. The pointer is set to 7Fh with stepping on and a single byte is written. A following read of two bytes must then return 00h and 05h, which shows that the step wrapped to 00h in the same cycle as the discarded write.

// File: rtl/i2cRegPkg.sv
package i2cRegPkg;

  localparam int PTR_W     = 7;
  localparam int NUM_SLOTS = 9;
  localparam logic [PTR_W-1:0] ID_ADDR = 7'h01;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_MAP,
    ST_WDATA,
    ST_ACK_SETUP,
    ST_ACK_HOLD,
    ST_RDATA,
    ST_RACK_SETUP,
    ST_RACK,
    ST_RNEXT,
    ST_WAIT
  } busState_t;

  // Pulses from control to datapath, one cycle each
  typedef struct packed {
    logic       loadMap;
    logic       writeReg;
    logic       advance;
    logic [7:0] data;
  } ctrlStrobe_t;

  function automatic logic [PTR_W-1:0] slotAddr(input int s);
    case (s)
      0:       return 7'h02;
      1:       return 7'h03;
      2:       return 7'h05;
      3:       return 7'h06;
      4:       return 7'h07;
      5:       return 7'h08;
      6:       return 7'h09;
      7:       return 7'h16;
      default: return 7'h17;
    endcase
  endfunction

  function automatic logic [7:0] slotMask(input int s);
    return (s == 0) ? 8'h1F : 8'hFF;
  endfunction

endpackage

// File: rtl/i2cRegCtrl.sv
module i2cRegCtrl
  import i2cRegPkg::*;
#(
  parameter logic [5:0] DEV_ADDR_HI = 6'b100111,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        addrStrap,
  input  logic        sclIn,
  input  logic        sdaIn,
  input  logic [7:0]  rdData,
  output ctrlStrobe_t strobe,
  output logic        sdaLowEn
);

  logic sclS, sdaS;

  generate
    if (SYNC_STAGES > 1) begin : gSync
      logic [SYNC_STAGES-1:0] sclPipe, sdaPipe;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclPipe <= '1;
          sdaPipe <= '1;
        end else begin
          sclPipe <= {sclPipe[SYNC_STAGES-2:0], sclIn};
          sdaPipe <= {sdaPipe[SYNC_STAGES-2:0], sdaIn};
        end
      end
      assign sclS = sclPipe[SYNC_STAGES-1];
      assign sdaS = sdaPipe[SYNC_STAGES-1];
    end else begin : gSingle
      logic sclQ, sdaQ;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          sclQ <= 1'b1;
          sdaQ <= 1'b1;
        end else begin
          sclQ <= sclIn;
          sdaQ <= sdaIn;
        end
      end
      assign sclS = sclQ;
      assign sdaS = sdaQ;
    end
  endgenerate

  logic prevScl, prevSda;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevScl <= 1'b1;
      prevSda <= 1'b1;
    end else begin
      prevScl <= sclS;
      prevSda <= sdaS;
    end
  end

  logic sclRise, sclFall, startSeen, stopSeen;
  assign sclRise   = sclS & ~prevScl;
  assign sclFall   = ~sclS & prevScl;
  assign startSeen = sclS & prevScl & prevSda & ~sdaS;
  assign stopSeen  = sclS & prevScl & ~prevSda & sdaS;

  busState_t  state, afterAck;
  logic [2:0] bitCnt;
  logic [7:0] rxShift, txShift;
  logic [7:0] rxByte;
  logic       addrHit;

  assign rxByte  = {rxShift[6:0], sdaS};
  assign addrHit = (rxByte[7:1] == {DEV_ADDR_HI, addrStrap});

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      afterAck <= ST_IDLE;
      bitCnt   <= '0;
      rxShift  <= '0;
      txShift  <= '0;
      sdaLowEn <= 1'b0;
      strobe   <= '0;
    end else begin
      strobe <= '0;
      if (startSeen) begin
        state    <= ST_ADDR;
        bitCnt   <= '0;
        sdaLowEn <= 1'b0;
      end else if (stopSeen) begin
        state    <= ST_IDLE;
        sdaLowEn <= 1'b0;
      end else begin
        case (state)
          ST_ADDR, ST_MAP, ST_WDATA: begin
            if (sclRise) begin
              rxShift <= rxByte;
              if (bitCnt == 3'd7) begin
                bitCnt      <= '0;
                strobe.data <= rxByte;
                state       <= ST_ACK_SETUP;
                if (state == ST_ADDR) begin
                  if (addrHit) afterAck <= rxByte[0] ? ST_RDATA : ST_MAP;
                  else         state    <= ST_WAIT;
                end else if (state == ST_MAP) begin
                  strobe.loadMap <= 1'b1;
                  afterAck       <= ST_WDATA;
                end else begin
                  strobe.writeReg <= 1'b1;
                  strobe.advance  <= 1'b1;
                  afterAck        <= ST_WDATA;
                end
              end else begin
                bitCnt <= bitCnt + 3'd1;
              end
            end
          end
          ST_ACK_SETUP: if (sclFall) begin
            sdaLowEn <= 1'b1;
            state    <= ST_ACK_HOLD;
          end
          ST_ACK_HOLD: if (sclFall) begin
            bitCnt <= '0;
            if (afterAck == ST_RDATA) begin
              txShift  <= rdData;
              sdaLowEn <= ~rdData[7];
            end else begin
              sdaLowEn <= 1'b0;
            end
            state <= afterAck;
          end
          ST_RDATA: begin
            if (sclFall) begin
              txShift  <= {txShift[6:0], 1'b0};
              sdaLowEn <= ~txShift[6];
            end else if (sclRise) begin
              if (bitCnt == 3'd7) begin
                strobe.advance <= 1'b1;
                state          <= ST_RACK_SETUP;
              end else begin
                bitCnt <= bitCnt + 3'd1;
              end
            end
          end
          ST_RACK_SETUP: if (sclFall) begin
            sdaLowEn <= 1'b0;
            state    <= ST_RACK;
          end
          ST_RACK: if (sclRise) state <= sdaS ? ST_WAIT : ST_RNEXT;
          ST_RNEXT: if (sclFall) begin
            bitCnt   <= '0;
            txShift  <= rdData;
            sdaLowEn <= ~rdData[7];
            state    <= ST_RDATA;
          end
          default: sdaLowEn <= 1'b0;
        endcase
      end
    end
  end

endmodule

// File: rtl/i2cRegData.sv
module i2cRegData
  import i2cRegPkg::*;
#(
  parameter logic [2:0] REV_CODE = 3'd5
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobe_t       strobe,
  output logic [7:0]        rdData,
  output logic              mapIncr,
  output logic [PTR_W-1:0]  mapPtr,
  output logic [31:0]       ratioWord
);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mapIncr <= 1'b0;
      mapPtr  <= '0;
    end else if (strobe.loadMap) begin
      mapIncr <= strobe.data[7];
      mapPtr  <= strobe.data[PTR_W-1:0];
    end else if (strobe.advance && mapIncr) begin
      mapPtr <= mapPtr + 1'b1;
    end
  end

  logic [7:0] slotQ [NUM_SLOTS];

  generate
    for (genvar s = 0; s < NUM_SLOTS; s++) begin : gSlot
      localparam logic [PTR_W-1:0] SLOT_ADDR = slotAddr(s);
      localparam logic [7:0]       SLOT_MASK = slotMask(s);
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN)                                    slotQ[s] <= '0;
        else if (strobe.writeReg && mapPtr == SLOT_ADDR) slotQ[s] <= strobe.data & SLOT_MASK;
      end
    end
  endgenerate

  always_comb begin
    rdData = '0;
    if (mapPtr == ID_ADDR) rdData = {5'b00000, REV_CODE};
    for (int s = 0; s < NUM_SLOTS; s++)
      if (mapPtr == slotAddr(s)) rdData = slotQ[s];
  end

  assign ratioWord = {slotQ[3], slotQ[4], slotQ[5], slotQ[6]};

endmodule

// File: rtl/i2cRegTarget.sv
module i2cRegTarget
  import i2cRegPkg::*;
#(
  parameter logic [5:0] DEV_ADDR_HI = 6'b100111,
  parameter logic [2:0] REV_CODE    = 3'd5,
  parameter int         SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        addrStrap,
  input  logic        sclIn,
  input  logic        sdaIn,
  output logic        sdaLowEn,
  output logic [31:0] ratioWord
);

  ctrlStrobe_t      strobe;
  logic [7:0]       rdData;
  logic             mapIncr;
  logic [PTR_W-1:0] mapPtr;

  i2cRegCtrl #(
    .DEV_ADDR_HI (DEV_ADDR_HI),
    .SYNC_STAGES (SYNC_STAGES)
  ) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .addrStrap (addrStrap),
    .sclIn     (sclIn),
    .sdaIn     (sdaIn),
    .rdData    (rdData),
    .strobe    (strobe),
    .sdaLowEn  (sdaLowEn)
  );

  i2cRegData #(
    .REV_CODE (REV_CODE)
  ) u_data (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .rdData    (rdData),
    .mapIncr   (mapIncr),
    .mapPtr    (mapPtr),
    .ratioWord (ratioWord)
  );

endmodule

// File: rtl/i2cRegTargetChk.sv
module i2cRegTargetChk
  import i2cRegPkg::*;
(
  input logic             clk,
  input logic             rstN,
  input logic             sclIn,
  input logic             sdaLowEn,
  input ctrlStrobe_t      strobe,
  input logic             mapIncr,
  input logic [PTR_W-1:0] mapPtr,
  input logic [31:0]      ratioWord
);

  // R1
  reset_release_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (!sdaLowEn && mapPtr == '0));

  // R11
  sda_only_scl_low_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sclIn && $past(sclIn)) |-> $stable(sdaLowEn));

  // R5
  ptr_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && mapIncr && !strobe.loadMap) |=> (mapPtr == PTR_W'($past(mapPtr) + 1'b1)));

  // R4
  ptr_fixed_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.advance && !mapIncr && !strobe.loadMap) |=> $stable(mapPtr));

  // R6
  ptr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!strobe.loadMap && !strobe.advance) |=> $stable({mapIncr, mapPtr}));

  // R8
  ratio_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.writeReg |=> $stable(ratioWord));

endmodule

bind i2cRegTarget i2cRegTargetChk u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .sclIn     (sclIn),
  .sdaLowEn  (sdaLowEn),
  .strobe    (strobe),
  .mapIncr   (mapIncr),
  .mapPtr    (mapPtr),
  .ratioWord (ratioWord)
);

// File: tb/test_i2cRegTarget.sv
module test_i2cRegTarget;

  localparam int CLK_PERIOD = 10;
  localparam int QTR        = 5;
  localparam int WATCHDOG   = 150000;
  localparam logic [7:0] WR_ADDR = 8'h9E;
  localparam logic [7:0] RD_ADDR = 8'h9F;
  localparam logic [7:0] ID_VAL  = 8'h05;

  typedef struct packed {
    logic [7:0] map;
    logic [7:0] wr;
    logic [7:0] exp;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{8'h03, 8'hA5, 8'hA5},
    '{8'h05, 8'h3C, 8'h3C},
    '{8'h01, 8'hFF, ID_VAL},
    '{8'h02, 8'hFF, 8'h1F},
    '{8'h06, 8'h12, 8'h12},
    '{8'h40, 8'h77, 8'h00},
    '{8'h16, 8'hC3, 8'hC3},
    '{8'h17, 8'h81, 8'h81}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic scl = 1'b1;
  logic sdaDrv = 1'b1;
  logic sdaLowEn;
  logic [31:0] ratioWord;
  wire  sdaBus = sdaDrv & ~sdaLowEn;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  i2cRegTarget i_i2cRegTarget (
    .clk       (clk),
    .rstN      (rstN),
    .addrStrap (1'b1),
    .sclIn     (scl),
    .sdaIn     (sdaBus),
    .sdaLowEn  (sdaLowEn),
    .ratioWord (ratioWord)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic waitQ();
    repeat (QTR) @(negedge clk);
  endtask

  task automatic startCond();
    sdaDrv = 1'b1; waitQ();
    scl = 1'b1;    waitQ();
    sdaDrv = 1'b0; waitQ();
    scl = 1'b0;    waitQ();
  endtask

  task automatic stopCond();
    sdaDrv = 1'b0; waitQ();
    scl = 1'b1;    waitQ();
    sdaDrv = 1'b1; waitQ();
  endtask

  task automatic writeBit(input logic b);
    sdaDrv = b; waitQ();
    scl = 1'b1; waitQ(); waitQ();
    scl = 1'b0; waitQ();
  endtask

  task automatic readBit(output logic b);
    sdaDrv = 1'b1; waitQ();
    scl = 1'b1;    waitQ();
    b = sdaBus;    waitQ();
    scl = 1'b0;    waitQ();
  endtask

  task automatic sendByte(input logic [7:0] v, output logic ack);
    logic bv;
    for (int i = 7; i >= 0; i--) writeBit(v[i]);
    readBit(bv);
    ack = ~bv;
  endtask

  task automatic recvByte(input logic nack, output logic [7:0] v);
    logic bv;
    for (int i = 7; i >= 0; i--) begin
      readBit(bv);
      v[i] = bv;
    end
    writeBit(nack);
  endtask

  task automatic wrTxn(input logic [7:0] map, input int n, input logic [31:0] data, output logic allAck);
    logic a;
    startCond();
    sendByte(WR_ADDR, a); allAck = a;
    sendByte(map, a);     allAck &= a;
    for (int i = 0; i < n; i++) begin
      sendByte(data[31-8*i -: 8], a);
      allAck &= a;
    end
    stopCond();
  endtask

  task automatic rdTxn(input int n, output logic [31:0] got, output logic adrAck);
    logic [7:0] b;
    got = '0;
    startCond();
    sendByte(RD_ADDR, adrAck);
    for (int i = 0; i < n; i++) begin
      recvByte(i == n - 1, b);
      got = {got[23:0], b};
    end
    stopCond();
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    finishRun();
  end

  initial begin
    logic ok, a, b2;
    logic [31:0] got;
    logic [7:0] bt;

    repeat (5) @(negedge clk);
    chk(sdaLowEn == 1'b0, "R1 sda released in reset", {31'b0, sdaLowEn}, 0);
    rstN = 1'b1;
    repeat (5) @(negedge clk);
    chk(sdaLowEn == 1'b0, "R1 sda released after reset", {31'b0, sdaLowEn}, 0);

    // R1: defaults of the ID and of a cleared register
    wrTxn(8'h01, 0, 0, ok);
    rdTxn(1, got, a);
    chk(got[7:0] == ID_VAL, "R1 id register", got, ID_VAL);
    wrTxn(8'h05, 0, 0, ok);
    rdTxn(1, got, a);
    chk(got[7:0] == 8'h00, "R1 reg 05h default", got, 0);
    chk(ratioWord == 32'h0, "R1 R8 ratio default", ratioWord, 0);

    // R3 R7 R6: table of single-register writes and read-back
    for (int v = 0; v < 8; v++) begin
      wrTxn(VECS[v].map, 1, {VECS[v].wr, 24'h0}, ok);
      chk(ok, "R3 ack of address, pointer and data", {31'b0, ok}, 1);
      wrTxn(VECS[v].map, 0, 0, ok);
      rdTxn(1, got, a);
      chk(got[7:0] == VECS[v].exp, "R7 R6 read back through kept pointer", got, VECS[v].exp);
    end

    // R4: fixed pointer, last of three writes stays in 03h
    wrTxn(8'h03, 3, 32'h11223300, ok);
    rdTxn(2, got, a);
    chk(got[15:0] == 16'h3333, "R4 fixed pointer write and read", got, 32'h3333);

    // R5 R8: block write and block read with stepping
    wrTxn(8'h86, 4, 32'hDEADBEEF, ok);
    chk(ratioWord == 32'hDEADBEEF, "R8 ratio word order", ratioWord, 32'hDEADBEEF);
    wrTxn(8'h86, 0, 0, ok);
    rdTxn(4, got, a);
    chk(got == 32'hDEADBEEF, "R5 block read", got, 32'hDEADBEEF);

    // R5: wrap from 7Fh to 00h, then reads 00h and 01h
    wrTxn(8'hFF, 1, 32'h55000000, ok);
    rdTxn(2, got, a);
    chk(got[15:0] == {8'h00, ID_VAL}, "R5 pointer wraps to 00h", got, {16'h0, 8'h00, ID_VAL});

    // R2: wrong address is not acknowledged, SDA stays released
    startCond();
    sendByte(8'h9C, a);
    chk(a == 1'b0, "R2 no ack for other address", {31'b0, a}, 0);
    sendByte(8'h55, a);
    chk(a == 1'b0, "R2 silent until stop", {31'b0, a}, 0);
    stopCond();
    wrTxn(8'h03, 0, 0, ok);
    rdTxn(1, got, a);
    chk(got[7:0] == 8'h33, "R2 register untouched", got, 32'h33);

    // R9: NACK ends the read, further clocks read released bus
    startCond();
    sendByte(RD_ADDR, a);
    recvByte(1'b1, bt);
    chk(bt == 8'h33, "R9 read byte before nack", {24'b0, bt}, 32'h33);
    recvByte(1'b1, bt);
    chk(bt == 8'hFF, "R9 released after nack", {24'b0, bt}, 32'hFF);
    stopCond();

    // R10: repeated start in mid data byte keeps pointer and value
    startCond();
    sendByte(WR_ADDR, a);
    sendByte(8'h03, a);
    writeBit(1'b1); writeBit(1'b0); writeBit(1'b1); writeBit(1'b0);
    startCond();
    sendByte(RD_ADDR, b2);
    chk(b2 == 1'b1, "R10 address after repeated start", {31'b0, b2}, 1);
    recvByte(1'b1, bt);
    stopCond();
    chk(bt == 8'h33, "R10 partial byte discarded", {24'b0, bt}, 32'h33);

    // R10: stop in mid pointer byte keeps the pointer
    startCond();
    sendByte(WR_ADDR, a);
    writeBit(1'b1); writeBit(1'b0); writeBit(1'b0);
    stopCond();
    rdTxn(1, got, a);
    chk(got[7:0] == 8'h33, "R10 pointer kept over stop abort", got, 32'h33);

    finishRun();
  end

endmodule